// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block keeps a free-running 64-bit time count for a processor core and raises a timer interrupt when that count has moved past a programmed deadline. The count is stored as two 32-bit words. It moves forward by a caller-supplied increment in every cycle where the tick enable is high, and a wrap of the lower word carries into the upper word.

Software reaches the block through a plain word-wide register port with read strobe, write strobe, address and data. The two count words can be read and the two deadline words can be written, each at a fixed full 32-bit address. The interrupt output is the result of a strict "count greater than deadline" test registered each cycle. A deadline of all zeros turns the interrupt off. A one-cycle wake pulse marks the cycle in which the interrupt first becomes pending, so that a core sleeping on wait-for-interrupt can resume.

Top module: `mtu_timer`

## Requirements
- R1: After reset the count and deadline are both zero, `irq_pending` and `wake_pulse` are low, and both count words read as zero.
- R2: In a cycle where `tick_en` is high, the 64-bit count grows by the zero-extended `tick_incr` at the clock edge. When `tick_en` is low the count holds, whatever `tick_incr` is.
- R3: When adding `tick_incr` overflows the lower count word, the lower word keeps the wrapped sum and the upper word rises by one in the same edge. Otherwise a tick leaves the upper word unchanged.
- R4: While `bus_rd` is high, address 0x1100BFF8 returns the lower count word and address 0x1100BFFC returns the upper count word, combinationally in the same cycle. While `bus_rd` is low, `bus_rdata` is zero.
- R5: A write (`bus_wr` high) to 0x11004000 loads the lower deadline word and a write to 0x11004004 loads the upper deadline word, at the clock edge.
- R6: `irq_pending` goes high one edge after the count becomes strictly greater than the deadline. A count equal to the deadline does not raise it.
- R7: The comparison looks at the upper words first. An upper count word above the upper deadline word raises `irq_pending` even if the lower count word is smaller. On equal upper words, the lower words decide.
- R8: While both deadline words are zero, `irq_pending` is low one edge later, whatever the count is.
- R9: `irq_pending` is not sticky. When the condition becomes false (for example, after a later deadline is written), it drops one edge later.
- R10: `wake_pulse` is high for exactly the one cycle in which `irq_pending` goes from low to high.
- R11: Reads of any address other than the two count addresses return zero. Writes to any address other than the two deadline addresses, including the count addresses, change neither the count nor the deadline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advance the count this cycle |
| tick_incr | input | 32 | Amount added to the count on an enabled tick |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_pending | output | 1 | Timer interrupt pending |
| wake_pulse | output | 1 | One-cycle pulse when the interrupt becomes pending |

## Verification
The bench uses the default 32-bit word and the default register addresses. A 32-bit increment can therefore wrap the lower word in a single tick of 0xFFFFFFFF, so carries into the upper word and upper-word-first comparisons are reached within a few dozen cycles. Deadlines are placed exactly at, one below, and across the word boundary from the count. This covers the strict-greater rule, equal upper words, and the all-zero disable.

// File: rtl/mtu_pkg.sv
package mtu_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_DL_LO,
    SEL_DL_HI
  } mtu_sel_e;

endpackage

// File: rtl/mtu_decode.sv
module mtu_decode #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] CNT_LO_ADR = 32'h1100_BFF8,
  parameter logic [31:0] CNT_HI_ADR = 32'h1100_BFFC,
  parameter logic [31:0] DL_LO_ADR  = 32'h1100_4000,
  parameter logic [31:0] DL_HI_ADR  = 32'h1100_4004
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  output mtu_pkg::mtu_sel_e    rd_sel,
  output logic                 wr_dl_lo,
  output logic                 wr_dl_hi
);
  import mtu_pkg::*;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(CNT_LO_ADR);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(CNT_HI_ADR);
  localparam logic [ADDR_W-1:0] A_DL_LO  = ADDR_W'(DL_LO_ADR);
  localparam logic [ADDR_W-1:0] A_DL_HI  = ADDR_W'(DL_HI_ADR);

  always_comb begin
    rd_sel = SEL_NONE;
    if (rd) begin
      if (addr == A_CNT_LO)      rd_sel = SEL_CNT_LO;
      else if (addr == A_CNT_HI) rd_sel = SEL_CNT_HI;
    end
  end

  assign wr_dl_lo = wr && (addr == A_DL_LO);
  assign wr_dl_hi = wr && (addr == A_DL_HI);

  // R11: no strobe toward the deadline without a bus write
  assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> !(wr_dl_lo || wr_dl_hi));
  // R4: no read selection without a read strobe
  assert_rd_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rd_sel == SEL_NONE));

endmodule

// File: rtl/mtu_counter.sv
module mtu_counter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [WORD_W-1:0] incr,
  output logic [WORD_W-1:0] cnt_lo,
  output logic [WORD_W-1:0] cnt_hi,
  output logic              lo_wrap
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  // Lower-word add with the carry kept as the top bit
  function automatic logic [WORD_W:0] add_carry(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [WORD_W:0] lo_sum;
  assign lo_sum  = add_carry(cnt_lo, incr);
  assign lo_wrap = tick_en && lo_sum[WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (tick_en) begin
      cnt_lo <= lo_sum[WORD_W-1:0];
      if (lo_wrap) cnt_hi <= cnt_hi + ONE;
    end
  end

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  assert_carry_bumps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (cnt_hi == $past(cnt_hi) + ONE));
  assert_no_carry_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !lo_wrap) |=> $stable(cnt_hi));

endmodule

// File: rtl/mtu_deadline.sv
module mtu_deadline #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] cnt_lo,
  input  logic [WORD_W-1:0] cnt_hi,
  output logic              pend,
  output logic              wake
);
  logic [WORD_W-1:0] dl_lo, dl_hi;
  logic              dl_zero, passed, fire;

  // Strict "count beyond deadline", upper words first
  function automatic logic beyond(input logic [WORD_W-1:0] c_hi,
                                  input logic [WORD_W-1:0] c_lo,
                                  input logic [WORD_W-1:0] d_hi,
                                  input logic [WORD_W-1:0] d_lo);
    if (c_hi != d_hi) return c_hi > d_hi;
    return c_lo > d_lo;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_lo <= '0;
      dl_hi <= '0;
    end else begin
      if (wr_lo) dl_lo <= wdata;
      if (wr_hi) dl_hi <= wdata;
    end
  end

  assign dl_zero = ~|{dl_hi, dl_lo};
  assign passed  = beyond(cnt_hi, cnt_lo, dl_hi, dl_lo);
  assign fire    = passed && !dl_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      wake <= 1'b0;
    end else begin
      pend <= fire;
      wake <= fire && !pend;
    end
  end

  assert_equal_not_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({cnt_hi, cnt_lo} == {dl_hi, dl_lo}) |=> !pend);
  assert_hi_word_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_hi > dl_hi) && !dl_zero) |=> pend);
  assert_zero_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dl_zero |=> !pend);
  assert_not_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !passed |=> !pend);
  assert_wake_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> wake);
  assert_wake_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  assert_deadline_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> ($stable(dl_lo) && $stable(dl_hi)));

endmodule

// File: rtl/mtu_timer.sv
module mtu_timer #(
  parameter int          WORD_W     = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] CNT_LO_ADR = 32'h1100_BFF8,
  parameter logic [31:0] CNT_HI_ADR = 32'h1100_BFFC,
  parameter logic [31:0] DL_LO_ADR  = 32'h1100_4000,
  parameter logic [31:0] DL_HI_ADR  = 32'h1100_4004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [WORD_W-1:0] tick_incr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_pending,
  output logic              wake_pulse
);
  import mtu_pkg::*;

  mtu_sel_e          rd_sel;
  logic              wr_dl_lo, wr_dl_hi, lo_wrap;
  logic [WORD_W-1:0] cnt_lo, cnt_hi;

  mtu_decode #(
    .ADDR_W(ADDR_W), .CNT_LO_ADR(CNT_LO_ADR), .CNT_HI_ADR(CNT_HI_ADR),
    .DL_LO_ADR(DL_LO_ADR), .DL_HI_ADR(DL_HI_ADR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .rd_sel(rd_sel), .wr_dl_lo(wr_dl_lo), .wr_dl_hi(wr_dl_hi)
  );

  mtu_counter #(.WORD_W(WORD_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .incr(tick_incr),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .lo_wrap(lo_wrap)
  );

  mtu_deadline #(.WORD_W(WORD_W)) u_deadline (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_dl_lo), .wr_hi(wr_dl_hi),
    .wdata(bus_wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .pend(irq_pending), .wake(wake_pulse)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_CNT_LO: bus_rdata = cnt_lo;
      SEL_CNT_HI: bus_rdata = cnt_hi;
      default:    bus_rdata = '0;
    endcase
  end

  // R3: a carry event never coincides with an idle tick
  assert_wrap_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |-> tick_en);
  // R4: reads of the lower count word follow the counter
  assert_read_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_CNT_LO) |-> (bus_rdata == cnt_lo));
  // R11: counter addresses never touch the deadline
  assert_cnt_addr_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CNT_LO_ADR)) |-> !(wr_dl_lo || wr_dl_hi));

endmodule

// File: tb/test_mtu_timer.sv
module test_mtu_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [31:0] tick_incr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pending, wake_pulse;

  int n_chk = 0;
  int n_bad = 0;
  longint unsigned m_cnt = 0;
  longint unsigned m_dl = 0;

  localparam logic [31:0] A_CLO = 32'h1100_BFF8;
  localparam logic [31:0] A_CHI = 32'h1100_BFFC;
  localparam logic [31:0] A_DLO = 32'h1100_4000;
  localparam logic [31:0] A_DHI = 32'h1100_4004;

  always #4 clk = ~clk;

  mtu_timer i_mtu_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_incr(tick_incr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pending(irq_pending), .wake_pulse(wake_pulse)
  );

  function automatic logic model_pend();
    return (m_dl != 0) && (m_cnt > m_dl);
  endfunction

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [31:0] inc);
    @(negedge clk); tick_en = 1'b1; tick_incr = inc;
    @(negedge clk); tick_en = 1'b0;
    m_cnt = m_cnt + longint'(inc);
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    if (a == A_DLO) m_dl = {m_dl[63:32], d};
    if (a == A_DHI) m_dl = {d, m_dl[31:0]};
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic chk_count(input string req);
    logic [31:0] lo, hi;
    bus_read(A_CLO, lo);
    bus_read(A_CHI, hi);
    chk(req, {hi, lo}, m_cnt);
  endtask

  task automatic t_reset();
    chk("R1 pending", irq_pending, 0);
    chk("R1 wake", wake_pulse, 0);
    chk_count("R1 count");
  endtask

  task automatic t_tick_gate();
    @(negedge clk); tick_en = 1'b0; tick_incr = 32'd7;
    settle();
    chk_count("R2 idle hold");
    tick(32'd5);
    chk_count("R2 tick add");
    settle();
    chk("R8 zero deadline", irq_pending, 0);
  endtask

  task automatic t_strict();
    bus_write(A_DLO, 32'd20);
    tick(32'd10);
    settle();
    chk("R5/R6 below", irq_pending, 0);
    tick(32'd5);
    settle();
    chk("R6 equal", irq_pending, 0);
    tick(32'd1);
    settle();
    chk("R6 beyond", irq_pending, 1);
    chk("R10 wake on rise", wake_pulse, 1);
    settle();
    chk("R10 wake one cycle", wake_pulse, 0);
    chk("R6 stays", irq_pending, 1);
  endtask

  task automatic t_clear();
    bus_write(A_DLO, 32'd100);
    settle();
    chk("R9 cleared", irq_pending, 0);
    chk("R10 no wake", wake_pulse, 0);
  endtask

  task automatic t_carry();
    tick(32'hFFFF_FFFF);
    chk_count("R3 carry into upper");
    chk_count("R4 read words");
    settle();
    chk("R7 upper above, lower below", irq_pending, model_pend());
  endtask

  task automatic t_tie();
    bus_write(A_DHI, 32'd1);
    settle();
    chk("R7 tie lower smaller", irq_pending, 0);
    tick(32'h50);
    settle();
    chk("R7 tie equal", irq_pending, 0);
    tick(32'd1);
    settle();
    chk("R7 tie lower larger", irq_pending, 1);
  endtask

  task automatic t_zero();
    bus_write(A_DHI, 32'd0);
    settle();
    chk("R5 upper deadline write", irq_pending, model_pend());
    bus_write(A_DLO, 32'd0);
    settle();
    chk("R8 all-zero disable", irq_pending, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(A_DLO, 32'd5);
    settle();
    chk("R5 lower deadline write", irq_pending, 1);
    bus_write(32'h1100_4008, 32'd0);
    bus_write(32'h1000_4000, 32'd0);
    bus_write(A_CLO, 32'd0);
    bus_write(A_CHI, 32'hFFFF_FFFF);
    settle();
    chk("R11 writes ignored pending", irq_pending, 1);
    chk_count("R11 count untouched");
    bus_read(A_DLO, d);
    chk("R11 deadline reads zero", d, 0);
    bus_read(32'h0000_0000, d);
    chk("R11 unmapped read", d, 0);
    @(negedge clk); bus_rd = 1'b0; bus_addr = A_CLO;
    #1 chk("R4 no strobe zero", bus_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_tick_gate();
    t_strict();
    t_clear();
    t_carry();
    t_tie();
    t_zero();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule